// File: doc/BRIEF.md
# Dual-Port Row-Streaming Video Memory

This block is a synthesizable behavioural model of a two-port video memory. A host reaches any byte through a random-access port. Each access runs an internal row cycle. The selected row is read as a whole into a set of row latches, and that read empties the row in the array. The addressed byte is taken from the latches. The full latch contents, with the new byte merged in on a write, then go back into the same row.

The second port is a serial output for a display pipeline. A transfer command on the random port runs the same row cycle. In its write-back cycle it also copies the whole row into a separate shift register. Each cycle in which the shift strobe is high moves the next bit of that copy onto a single output pin, in increasing bit order. Because the shift register is separate from the row latches, the host keeps reading and writing while the stream runs.

Top module: `vram_dual_port`

## Requirements
- R1: During and just after reset, `acc_ready` and `xfer_ready` are 1, and `rd_valid`, `ser_dout` and `ser_eor` are 0.
- R2: An access taken at clock edge N (`acc_req` and `acc_ready` high before it) drives `rd_valid` high for exactly the one cycle after edge N+1. In that cycle `rd_data` holds bits 8k to 8k+7 of row `acc_row`, where k is `acc_col`, with bit 8k as the LSB.
- R3: A write access (`acc_we`=1) replaces only the addressed byte of the row. Its `rd_data` returns the byte's previous content.
- R4: Every access and every transfer writes the full row back after the destructive row read, so later reads of any byte of that row return the same data.
- R5: While a row cycle is in progress (the cycle after acceptance), `acc_ready` and `xfer_ready` are 0. A request presented while not ready has no effect.
- R6: A transfer taken at edge N loads the whole row into the shift register at edge N+1 and restarts the stream at bit 0. A shift strobe present in the cycle before edge N+1 is ignored.
- R7: At each edge where `shift_en` is high and no load occurs, `ser_dout` takes the next bit of the transferred row, starting at bit 0 and increasing. With `shift_en` low, `ser_dout` holds.
- R8: After bit 1023 the stream wraps to bit 0. `ser_eor` is high for exactly the one cycle in which `ser_dout` shows bit 1023.
- R9: If `xfer_req` and `acc_req` are both high while the block is idle, the transfer is taken. `acc_ready` stays 0 for as long as `xfer_req` is high.
- R10: Host reads and writes, including writes to the transferred row, do not change the bits already held for serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Random access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_row | input | 6 | Row of the access |
| acc_col | input | 7 | Byte index within the row |
| acc_wdata | input | 8 | Write byte |
| acc_ready | output | 1 | Access is taken at the next edge when high |
| rd_data | output | 8 | Byte read (previous content on writes) |
| rd_valid | output | 1 | `rd_data` valid for this cycle |
| xfer_req | input | 1 | Row-to-shift-register transfer request |
| xfer_row | input | 6 | Row to transfer |
| xfer_ready | output | 1 | Transfer is taken at the next edge when high |
| shift_en | input | 1 | Shift strobe, one bit per high cycle |
| ser_dout | output | 1 | Serial data bit |
| ser_eor | output | 1 | Last bit of the row is on `ser_dout` |

## Verification
Several checks run on every cycle. The array never sees a row read and a write-back in the same cycle. Each taken request is followed by a write-back to the same row. A conflict always resolves into a transfer. Every write-back of an access yields a read result. A load resets the bit counter, and the end-of-row flag lasts one cycle and only follows a shift. Data correctness needs the bench's reference model and its scenarios. These include byte placement within the 1,024-bit row, retention across the destructive read, the exact bit order and wrap of the stream, and the fact that host writes to a row being streamed leave the stream unchanged.

// File: rtl/vram_pkg.sv
package vram_pkg;
  typedef enum logic {
    OP_ACC  = 1'b0,
    OP_XFER = 1'b1
  } vram_op_e;
endpackage

// File: rtl/vram_cell_array.sv
module vram_cell_array #(
  parameter int ROWS     = 64,
  parameter int ROW_BITS = 1024,
  localparam int ROW_AW  = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ROW_AW-1:0]   rd_row,
  output logic [ROW_BITS-1:0] row_latch,
  input  logic                wb_en,
  input  logic [ROW_AW-1:0]   wb_row,
  input  logic [ROW_BITS-1:0] wb_data
);
  logic [ROW_BITS-1:0] cells [ROWS];

  // A row read empties the row; only the write-back restores it.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      row_latch      <= cells[rd_row];
      cells[rd_row]  <= '0;
    end else if (wb_en) begin
      cells[wb_row]  <= wb_data;
    end
  end

  // R4
  single_op_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_en, wb_en}));
endmodule

// File: rtl/vram_row_seq.sv
module vram_row_seq
  import vram_pkg::*;
#(
  parameter int ROWS     = 64,
  parameter int ROW_BITS = 1024,
  parameter int BYTE_W   = 8,
  localparam int ROW_AW  = $clog2(ROWS),
  localparam int COL_AW  = $clog2(ROW_BITS / BYTE_W),
  localparam int BIT_AW  = $clog2(ROW_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_req,
  input  logic                acc_we,
  input  logic [ROW_AW-1:0]   acc_row,
  input  logic [COL_AW-1:0]   acc_col,
  input  logic [BYTE_W-1:0]   acc_wdata,
  input  logic                xfer_req,
  input  logic [ROW_AW-1:0]   xfer_row,
  output logic                acc_ready,
  output logic                xfer_ready,
  output logic                rd_en,
  output logic [ROW_AW-1:0]   rd_row,
  input  logic [ROW_BITS-1:0] row_latch,
  output logic                wb_en,
  output logic [ROW_AW-1:0]   wb_row,
  output logic [ROW_BITS-1:0] wb_data,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                load
);
  logic              busy_q;
  vram_op_e          op_q;
  logic [ROW_AW-1:0] row_q;
  logic [COL_AW-1:0] col_q;
  logic              we_q;
  logic [BYTE_W-1:0] wd_q;
  logic              take_xfer, take_acc;
  logic [BIT_AW-1:0] bsel;

  assign take_xfer  = xfer_req && !busy_q;
  assign take_acc   = acc_req && !busy_q && !xfer_req;
  assign acc_ready  = !busy_q && !xfer_req;
  assign xfer_ready = !busy_q;
  assign rd_en      = take_xfer || take_acc;
  assign rd_row     = take_xfer ? xfer_row : acc_row;
  assign wb_en      = busy_q;
  assign wb_row     = row_q;
  assign load       = busy_q && (op_q == OP_XFER);
  assign bsel       = BIT_AW'(col_q) << $clog2(BYTE_W);

  always_comb begin
    wb_data = row_latch;
    if (busy_q && op_q == OP_ACC && we_q) wb_data[bsel +: BYTE_W] = wd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      op_q     <= OP_ACC;
      row_q    <= '0;
      col_q    <= '0;
      we_q     <= 1'b0;
      wd_q     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (busy_q) begin
        busy_q <= 1'b0;
        if (op_q == OP_ACC) begin
          rd_data  <= row_latch[bsel +: BYTE_W];
          rd_valid <= 1'b1;
        end
      end else if (take_xfer) begin
        busy_q <= 1'b1;
        op_q   <= OP_XFER;
        row_q  <= xfer_row;
      end else if (take_acc) begin
        busy_q <= 1'b1;
        op_q   <= OP_ACC;
        row_q  <= acc_row;
        col_q  <= acc_col;
        we_q   <= acc_we;
        wd_q   <= acc_wdata;
      end
    end
  end

  // R4
  wb_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (wb_en && wb_row == $past(rd_row)));
  // R2
  rd_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !load) |=> rd_valid);
  // R9
  xfer_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && xfer_req && xfer_ready) |=> (load && !rd_valid));
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (!rd_en && !acc_ready));
endmodule

// File: rtl/vram_serial_out.sv
module vram_serial_out #(
  parameter int ROW_BITS = 1024,
  localparam int BIT_AW  = $clog2(ROW_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [ROW_BITS-1:0] load_data,
  input  logic                shift_i,
  output logic                dout_o,
  output logic                eor_o
);
  localparam logic [BIT_AW-1:0] LAST = BIT_AW'(ROW_BITS - 1);

  logic [ROW_BITS-1:0] sreg;
  logic [BIT_AW-1:0]   cnt;

  // Rotating register: after a full row it is back in its loaded order.
  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      cnt    <= '0;
      dout_o <= 1'b0;
      eor_o  <= 1'b0;
    end else begin
      eor_o <= 1'b0;
      if (load_i) begin
        sreg <= load_data;
        cnt  <= '0;
      end else if (shift_i) begin
        dout_o <= sreg[0];
        sreg   <= {sreg[0], sreg[ROW_BITS-1:1]};
        cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
        eor_o  <= (cnt == LAST);
      end
    end
  end

  // R6
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt == '0));
  // R8
  eor_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eor_o |=> !eor_o);
  // R8
  eor_cause_chk: assert property (@(posedge clk) disable iff (rst)
    eor_o |-> $past(shift_i && !load_i));
endmodule

// File: rtl/vram_dual_port.sv
module vram_dual_port #(
  parameter int ROWS     = 64,
  parameter int ROW_BITS = 1024,
  parameter int BYTE_W   = 8,
  localparam int ROW_AW  = $clog2(ROWS),
  localparam int COL_AW  = $clog2(ROW_BITS / BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [ROW_AW-1:0] acc_row,
  input  logic [COL_AW-1:0] acc_col,
  input  logic [BYTE_W-1:0] acc_wdata,
  output logic              acc_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              xfer_req,
  input  logic [ROW_AW-1:0] xfer_row,
  output logic              xfer_ready,
  input  logic              shift_en,
  output logic              ser_dout,
  output logic              ser_eor
);
  logic                rd_en, wb_en, load;
  logic [ROW_AW-1:0]   rd_row, wb_row;
  logic [ROW_BITS-1:0] row_latch, wb_data;

  vram_cell_array #(.ROWS(ROWS), .ROW_BITS(ROW_BITS)) u_array (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_row(rd_row), .row_latch(row_latch),
    .wb_en(wb_en), .wb_row(wb_row), .wb_data(wb_data)
  );

  vram_row_seq #(.ROWS(ROWS), .ROW_BITS(ROW_BITS), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst),
    .acc_req(acc_req), .acc_we(acc_we), .acc_row(acc_row),
    .acc_col(acc_col), .acc_wdata(acc_wdata),
    .xfer_req(xfer_req), .xfer_row(xfer_row),
    .acc_ready(acc_ready), .xfer_ready(xfer_ready),
    .rd_en(rd_en), .rd_row(rd_row), .row_latch(row_latch),
    .wb_en(wb_en), .wb_row(wb_row), .wb_data(wb_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .load(load)
  );

  vram_serial_out #(.ROW_BITS(ROW_BITS)) u_ser (
    .clk(clk), .rst(rst),
    .load_i(load), .load_data(row_latch),
    .shift_i(shift_en), .dout_o(ser_dout), .eor_o(ser_eor)
  );
endmodule

// File: tb/test_vram_dual_port.sv
`timescale 1ns/1ps
module test_vram_dual_port;
  logic       clk = 0;
  logic       rst = 1;
  logic       acc_req = 0, acc_we = 0, xfer_req = 0, shift_en = 0;
  logic [5:0] acc_row = 0, xfer_row = 0;
  logic [6:0] acc_col = 0;
  logic [7:0] acc_wdata = 0;
  logic       acc_ready, rd_valid, xfer_ready, ser_dout, ser_eor;
  logic [7:0] rd_data;

  int vectors = 0, fails = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  vram_dual_port i_vram_dual_port (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_we(acc_we),
    .acc_row(acc_row), .acc_col(acc_col), .acc_wdata(acc_wdata),
    .acc_ready(acc_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .xfer_req(xfer_req), .xfer_row(xfer_row), .xfer_ready(xfer_ready),
    .shift_en(shift_en), .ser_dout(ser_dout), .ser_eor(ser_eor)
  );

  // Behavioural reference: whole-row bit vectors and an integer stream position.
  logic [1023:0] m_mem [64];
  logic [1023:0] m_snap;
  int            m_pos, m_row, m_col;
  bit            m_busy, m_isx, m_we, ld;
  logic [7:0]    m_wd, exp_rdata;
  bit            exp_rvalid, exp_dout, exp_eor;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; exp_rvalid = 0; exp_dout = 0; exp_eor = 0;
      m_pos = 0; m_snap = '0;
    end else begin
      ld = 0;
      exp_rvalid = 0;
      exp_eor = 0;
      if (m_busy) begin
        m_busy = 0;
        if (m_isx) begin
          m_snap = m_mem[m_row]; m_pos = 0; ld = 1;
        end else begin
          exp_rdata  = m_mem[m_row][m_col*8 +: 8];
          exp_rvalid = 1;
          if (m_we) m_mem[m_row][m_col*8 +: 8] = m_wd;
        end
      end else if (xfer_req) begin
        m_busy = 1; m_isx = 1; m_row = int'(xfer_row);
      end else if (acc_req) begin
        m_busy = 1; m_isx = 0; m_row = int'(acc_row); m_col = int'(acc_col);
        m_we = acc_we; m_wd = acc_wdata;
      end
      if (!ld && shift_en) begin
        exp_dout = m_snap[m_pos];
        exp_eor  = (m_pos == 1023);
        m_pos    = (m_pos + 1) % 1024;
      end
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t got %h expected %h", req, phase, $time, got, exp);
    end
  endtask

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      chk("R1 acc_ready", 32'(acc_ready), 32'd1);
      chk("R1 xfer_ready", 32'(xfer_ready), 32'd1);
    end else begin
      chk("R2 rd_valid", 32'(rd_valid), 32'(exp_rvalid));
      if (exp_rvalid && !$isunknown(exp_rdata))
        chk("R2/R3/R4 rd_data", 32'(rd_data), 32'(exp_rdata));
      chk("R5/R9 acc_ready", 32'(acc_ready), 32'(!m_busy && !xfer_req));
      chk("R5 xfer_ready", 32'(xfer_ready), 32'(!m_busy));
      chk("R7/R10 ser_dout", 32'(ser_dout), 32'(exp_dout));
      chk("R8 ser_eor", 32'(ser_eor), 32'(exp_eor));
    end
  end

  task automatic do_acc(bit we, int row, int col, int wd);
    bit ok = 0;
    @(posedge clk); #1;
    acc_req = 1; acc_we = we; acc_row = 6'(row); acc_col = 7'(col); acc_wdata = 8'(wd);
    while (!ok) begin
      #1; ok = acc_ready;
      @(posedge clk);
      if (!ok) #1;
    end
    #1 acc_req = 0;
  endtask

  task automatic do_xfer(int row);
    bit ok = 0;
    @(posedge clk); #1;
    xfer_req = 1; xfer_row = 6'(row);
    while (!ok) begin
      #1; ok = xfer_ready;
      @(posedge clk);
      if (!ok) #1;
    end
    #1 xfer_req = 0;
  endtask

  task automatic shift_n(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      shift_en = (gap == 0) || (i % gap != 0);
    end
    @(posedge clk); #1 shift_en = 0;
  endtask

  function automatic int pat(int r, int c);
    return ((r * 37) + (c * 11)) ^ 8'h5A;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got hung expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    chk("R1 ser_dout", 32'(ser_dout), 32'd0);
    chk("R1 ser_eor", 32'(ser_eor), 32'd0);

    // R3: fill three rows, including both row-address extremes
    phase = "R3";
    foreach (m_mem[r]) if (r == 0 || r == 3 || r == 63)
      for (int c = 0; c < 128; c++) do_acc(1, r, c, pat(r, c));

    // R2/R4: reads, repeated reads of the same byte, byte extremes
    phase = "R4";
    do_acc(0, 3, 0, 0);
    do_acc(0, 3, 0, 0);
    do_acc(0, 63, 127, 0);
    do_acc(0, 0, 64, 0);
    do_acc(1, 3, 10, 8'hC3);
    do_acc(0, 3, 10, 0);
    do_acc(0, 3, 11, 0);

    // R9: conflict, transfer wins; R5 back-to-back pressure
    phase = "R9";
    fork
      do_xfer(3);
      do_acc(0, 0, 5, 0);
    join

    // R7/R8: full row plus wrap, with strobe gaps
    phase = "R8";
    shift_n(1300, 5);

    // R10: host traffic to the streamed row during shifting
    phase = "R10";
    fork
      shift_n(400, 0);
      begin
        for (int c = 0; c < 40; c++) do_acc(1, 3, c, 8'hFF ^ c);
        do_acc(0, 3, 3, 0);
        do_acc(0, 0, 100, 0);
      end
    join

    // R6: transfer while the strobe stays high
    phase = "R6";
    fork
      shift_n(30, 0);
      do_xfer(63);
    join
    shift_n(1040, 0);
    do_xfer(3);
    shift_n(1030, 0);

    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule